// File: doc/BRIEF.md
# Serial EEPROM Slave Protocol Engine

This block is the byte-level slave engine of a two-wire serial EEPROM. A condition detector in front of it supplies one-cycle strobes for START, STOP, SCL rising edge and SCL falling edge, along with a filtered copy of the data line. The engine shifts bits in on SCL rising edges, drives an open-drain pull-down enable for the data line, and changes that enable only on SCL falling edges. It checks the first byte of each transfer against a fixed device code and the strap inputs, then runs the write and read commands.

The write commands cover byte write, page write and dummy write. Data bytes are gathered in a one-page buffer and handed to an internal write-cycle timer when a STOP arrives right after an acknowledged data byte. While that timer runs, the buffered bytes are copied into a register array that stands in for the nonvolatile cells, and the engine answers no traffic. The read commands cover current-address read, random read and sequential read, all driven from a shared address counter. A write-protect input blocks every data byte.

Top module: `eeprom_slave_engine`

## Requirements
- R1: After reset, the pull-down enable is low, busy is low, and every memory location reads back as 0xFF.
- R2: The engine acknowledges the first byte after START by pulling the line low during the ninth clock only under three conditions. Bits 7:4 must equal 1010. The select bits must equal the straps: with the default 512-byte size, bits 3:2 are compared with strap bits 2:1, and bit 1 is a page bit that is not compared. The engine must not be busy. Bit 0 is R/W, where 1 means read. Any other first byte gets no acknowledge, and the engine stays silent until the next START.
- R3: In a write command, the word-address byte and each data byte are acknowledged. The byte address is formed from the page bits of the first byte above the 8-bit word address.
- R4: Once a write cycle starts, busy is high for WR_CYCLES clocks. During that time no byte is acknowledged, including the device address, so a master can poll for completion.
- R5: With the write-protect input high, the device address and the word address are acknowledged. Every data byte gets no acknowledge, no write cycle starts, and memory is unchanged.
- R6: A write cycle starts only when STOP follows directly after an acknowledged data byte. A STOP after the word address (dummy write) only loads the address counter. A STOP partway through a data byte starts nothing.
- R7: A random read is a dummy write, then a new START and a read address. It returns the byte at the loaded address, MSB first.
- R8: During a read, a master acknowledge makes the engine send the byte at the next address. The address wraps from the top location to 0. A current-address read continues from the address counter.
- R9: A START arriving at any point cancels the command in progress. A pending write is dropped.
- R10: During a page write, only the low log2(PAGE_BYTES) address bits advance. Extra bytes wrap within the page and leave the upper bits unchanged.
- R11: A master NACK after a read byte ends the read. The engine releases the line and drives nothing until the next START. A STOP always releases the line.
- R12: The pull-down enable changes only in the cycle after an SCL falling edge, START or STOP strobe. It therefore holds steady while SCL is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| startStb | input | 1 | One-cycle START condition strobe |
| stopStb | input | 1 | One-cycle STOP condition strobe |
| sclRise | input | 1 | One-cycle SCL rising-edge strobe |
| sclFall | input | 1 | One-cycle SCL falling-edge strobe |
| sdaIn | input | 1 | Filtered data-line level |
| strapAddr | input | 3 | Device-select strap inputs |
| wpIn | input | 1 | Write protect, high blocks data writes |
| sdaOe | output | 1 | Pull data line low when high |
| busy | output | 1 | Internal write cycle in progress |

## Verification
Two functions can meet in the same cycle. The first is the commit decision for a write. The second is the receive shifter, which takes the SCL rise that always comes before a STOP. A commit must still count that rise as "directly after the acknowledge". Each write ends with that rise followed by the STOP, so this overlap is provoked every time, and a sent-but-truncated byte sets the contrast. The result is judged by whether busy rises and by what a later readback returns. Device-address polling during the write time covers a second overlap: the address comparison against the busy state.

// File: rtl/eep_pkg.sv
package eep_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_DEV, S_WADR, S_WDAT, S_RDAT
  } eep_state_e;

  typedef struct packed {
    logic shiftIn;
    logic devAccept;
    logic loadAddr;
    logic storeData;
    logic loadTx;
    logic shiftTx;
    logic incAddr;
    logic commit;
  } eep_strobe_t;

  localparam logic [3:0] DEV_CODE = 4'b1010;
endpackage

// File: rtl/eep_ctrl.sv
module eep_ctrl
  import eep_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        startStb,
  input  logic        stopStb,
  input  logic        sclRise,
  input  logic        sclFall,
  input  logic        sdaIn,
  input  logic        wpIn,
  input  logic        devMatch,
  input  logic        rwBit,
  output eep_strobe_t stb,
  output logic        driveAck,
  output logic        driveData
);
  eep_state_e state;
  logic [3:0] bitCnt;
  logic       rdMode;
  logic       masterAck;
  logic       lastAck;
  logic       edgeOk;
  logic       rxState;
  logic       fall8;
  logic       fall9;

  assign edgeOk  = !startStb && !stopStb;
  assign rxState = (state == S_DEV) || (state == S_WADR) || (state == S_WDAT);
  assign fall8   = edgeOk && sclFall && (bitCnt == 4'd8);
  assign fall9   = edgeOk && sclFall && (bitCnt == 4'd9);

  always_comb begin
    stb           = '0;
    stb.shiftIn   = edgeOk && sclRise && rxState && (bitCnt < 4'd8);
    stb.devAccept = fall8 && (state == S_DEV) && devMatch;
    stb.loadAddr  = fall8 && (state == S_WADR);
    stb.storeData = fall8 && (state == S_WDAT) && !wpIn;
    stb.loadTx    = fall9 && (((state == S_DEV) && rdMode) ||
                              ((state == S_RDAT) && masterAck));
    stb.shiftTx   = edgeOk && sclFall && (state == S_RDAT) &&
                    (bitCnt >= 4'd1) && (bitCnt <= 4'd7);
    stb.incAddr   = fall8 && (state == S_RDAT);
    stb.commit    = stopStb && !startStb && (state == S_WDAT) &&
                    (bitCnt <= 4'd1) && lastAck;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      bitCnt    <= '0;
      rdMode    <= 1'b0;
      masterAck <= 1'b0;
      lastAck   <= 1'b0;
      driveAck  <= 1'b0;
      driveData <= 1'b0;
    end else if (startStb) begin
      state     <= S_DEV;
      bitCnt    <= '0;
      lastAck   <= 1'b0;
      driveAck  <= 1'b0;
      driveData <= 1'b0;
    end else if (stopStb) begin
      state     <= S_IDLE;
      bitCnt    <= '0;
      lastAck   <= 1'b0;
      driveAck  <= 1'b0;
      driveData <= 1'b0;
    end else if (sclRise) begin
      if ((rxState || state == S_RDAT) && bitCnt < 4'd8)
        bitCnt <= bitCnt + 4'd1;
      else if (state == S_RDAT && bitCnt == 4'd9)
        masterAck <= !sdaIn;
    end else if (sclFall && state != S_IDLE) begin
      if (bitCnt == 4'd8) begin
        bitCnt <= 4'd9;
        unique case (state)
          S_DEV: begin
            if (devMatch) begin
              driveAck <= 1'b1;
              rdMode   <= rwBit;
            end else begin
              state  <= S_IDLE;
              bitCnt <= '0;
            end
          end
          S_WADR:  driveAck <= 1'b1;
          S_WDAT: begin
            driveAck <= !wpIn;
            lastAck  <= !wpIn;
          end
          default: driveData <= 1'b0;
        endcase
      end else if (bitCnt == 4'd9) begin
        driveAck <= 1'b0;
        bitCnt   <= '0;
        unique case (state)
          S_DEV: begin
            state     <= rdMode ? S_RDAT : S_WADR;
            driveData <= rdMode;
          end
          S_WADR:  state <= S_WDAT;
          S_RDAT: begin
            if (masterAck) driveData <= 1'b1;
            else           state     <= S_IDLE;
          end
          default: ;
        endcase
      end
    end
  end

  // R5: a protected data byte never gets an acknowledge
  p_wp_nack_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fall8 && state == S_WDAT && wpIn) |=> !driveAck);

  // R11: master NACK ends the read; nothing is driven afterwards
  p_nack_ends_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (fall9 && state == S_RDAT && !masterAck) |=> (state == S_IDLE && !driveData));
endmodule

// File: rtl/eep_datapath.sv
module eep_datapath
  import eep_pkg::*;
#(
  parameter int ADDR_W     = 9,
  parameter int PAGE_BYTES = 16,
  parameter int WR_CYCLES  = 5000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  eep_strobe_t stb,
  input  logic        sdaIn,
  input  logic [2:0]  strapAddr,
  output logic        devMatch,
  output logic        rwBit,
  output logic        txMsb,
  output logic        busy
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PW    = $clog2(PAGE_BYTES);
  localparam int PSW   = ADDR_W - 8;
  localparam int HW    = (PSW > 0) ? PSW : 1;
  localparam int CYC   = (WR_CYCLES > PAGE_BYTES) ? WR_CYCLES : PAGE_BYTES;
  localparam int CW    = $clog2(CYC + 1);
  localparam logic [2:0] CMP_MASK = 3'(7 << PSW);

  logic [7:0]        rxByte;
  logic [7:0]        txShift;
  logic [ADDR_W-1:0] addrCnt;
  logic [ADDR_W-1:0] addrLoad;
  logic [HW-1:0]     devHi;
  logic [7:0]        mem [DEPTH];
  logic [7:0]        pageBuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] pageMask;
  logic [CW-1:0]     wrCnt;
  logic [PW-1:0]     wrIdx;
  logic              busyQ;

  assign devMatch = (rxByte[7:4] == DEV_CODE) &&
                    (((rxByte[3:1] ^ strapAddr) & CMP_MASK) == 3'b000) && !busyQ;
  assign rwBit    = rxByte[0];
  assign txMsb    = txShift[7];
  assign busy     = busyQ;
  assign wrIdx    = wrCnt[PW-1:0];

  generate
    if (PSW == 0) begin : g_flat
      assign addrLoad = rxByte;
    end else begin : g_paged
      assign addrLoad = {devHi[PSW-1:0], rxByte};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxByte  <= '0;
      txShift <= '0;
      devHi   <= '0;
    end else begin
      if (stb.shiftIn)   rxByte <= {rxByte[6:0], sdaIn};
      if (stb.devAccept) devHi  <= rxByte[HW:1];
      if (stb.loadTx)       txShift <= mem[addrCnt];
      else if (stb.shiftTx) txShift <= {txShift[6:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      addrCnt <= '0;
    else if (stb.loadAddr)
      addrCnt <= addrLoad;
    else if (stb.storeData)
      addrCnt <= {addrCnt[ADDR_W-1:PW], addrCnt[PW-1:0] + PW'(1)};
    else if (stb.incAddr)
      addrCnt <= addrCnt + ADDR_W'(1);
  end

  always_ff @(posedge clk) begin
    if (stb.storeData) pageBuf[addrCnt[PW-1:0]] <= rxByte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      pageMask <= '0;
    else if (stb.devAccept && !rxByte[0])
      pageMask <= '0;
    else if (stb.storeData)
      pageMask[addrCnt[PW-1:0]] <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busyQ <= 1'b0;
      wrCnt <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (stb.commit) begin
      busyQ <= 1'b1;
      wrCnt <= '0;
    end else if (busyQ) begin
      if (wrCnt < CW'(PAGE_BYTES) && pageMask[wrIdx])
        mem[{addrCnt[ADDR_W-1:PW], wrIdx}] <= pageBuf[wrIdx];
      if (wrCnt == CW'(CYC - 1)) busyQ <= 1'b0;
      wrCnt <= wrCnt + CW'(1);
    end
  end

  // R6: a write cycle only starts with buffered data
  p_commit_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stb.commit |-> (pageMask != '0));

  // R4: no new commit can land inside a running write cycle
  p_commit_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    stb.commit |-> !busyQ);
endmodule

// File: rtl/eeprom_slave_engine.sv
module eeprom_slave_engine
  import eep_pkg::*;
#(
  parameter int ADDR_W     = 9,
  parameter int PAGE_BYTES = 16,
  parameter int WR_CYCLES  = 5000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       startStb,
  input  logic       stopStb,
  input  logic       sclRise,
  input  logic       sclFall,
  input  logic       sdaIn,
  input  logic [2:0] strapAddr,
  input  logic       wpIn,
  output logic       sdaOe,
  output logic       busy
);
  eep_strobe_t stb;
  logic devMatch, rwBit, txMsb, driveAck, driveData;

  eep_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .startStb(startStb), .stopStb(stopStb),
    .sclRise(sclRise), .sclFall(sclFall), .sdaIn(sdaIn), .wpIn(wpIn),
    .devMatch(devMatch), .rwBit(rwBit), .stb(stb),
    .driveAck(driveAck), .driveData(driveData)
  );

  eep_datapath #(
    .ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .WR_CYCLES(WR_CYCLES)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .stb(stb), .sdaIn(sdaIn),
    .strapAddr(strapAddr), .devMatch(devMatch), .rwBit(rwBit),
    .txMsb(txMsb), .busy(busy)
  );

  assign sdaOe = driveAck | (driveData & ~txMsb);

  // R4: silent on the bus for the whole write time
  p_no_ack_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sdaOe);

  // R11: a STOP always frees the line
  p_stop_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
    stopStb |=> !sdaOe);

  // R12: the enable only moves after a falling edge, START or STOP
  p_oe_at_fall_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdaOe) |-> $past(sclFall || startStb || stopStb));
endmodule

// File: tb/eeprom_slave_engine_test.sv
module eeprom_slave_engine_test;
  localparam int WRC = 400;
  localparam logic [2:0] STRAP = 3'b010;

  logic clk = 0, rst_n = 0;
  logic startStb = 0, stopStb = 0, sclRise = 0, sclFall = 0, sdaIn = 1, wpIn = 0;
  logic sdaOe, busy;
  int nChecks = 0, nFail = 0;

  eeprom_slave_engine #(.ADDR_W(9), .PAGE_BYTES(16), .WR_CYCLES(WRC)) uut (
    .clk(clk), .rst_n(rst_n), .startStb(startStb), .stopStb(stopStb),
    .sclRise(sclRise), .sclFall(sclFall), .sdaIn(sdaIn), .strapAddr(STRAP),
    .wpIn(wpIn), .sdaOe(sdaOe), .busy(busy)
  );

  always #10 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] devB(input logic pg, input logic rw);
    return {4'b1010, STRAP[2:1], pg, rw};
  endfunction

  task automatic bitClock(input logic mb, output logic slaveLow, output logic preLow);
    sdaIn = mb; tick(2);
    preLow = sdaOe;
    sclRise = 1; tick(1); sclRise = 0; tick(2);
    slaveLow = sdaOe;
    sclFall = 1; tick(1); sclFall = 0; tick(2);
  endtask

  task automatic startCond;
    sdaIn = 1; tick(2);
    sclRise = 1; tick(1); sclRise = 0; tick(2);
    startStb = 1; tick(1); startStb = 0; tick(2);
    sclFall = 1; tick(1); sclFall = 0; tick(2);
  endtask

  task automatic stopCond;
    sdaIn = 0; tick(2);
    sclRise = 1; tick(1); sclRise = 0; tick(2);
    stopStb = 1; tick(1); stopStb = 0; sdaIn = 1; tick(2);
  endtask

  task automatic sendByte(input logic [7:0] b, output logic acked);
    logic lo, pre;
    for (int i = 7; i >= 0; i--) bitClock(b[i], lo, pre);
    bitClock(1'b1, lo, pre);
    acked = lo;
  endtask

  task automatic readByte(input logic ackIt, output logic [7:0] d, output logic steady);
    logic lo, pre;
    steady = 1;
    for (int i = 7; i >= 0; i--) begin
      bitClock(1'b1, lo, pre);
      d[i] = ~lo;
      if (lo !== pre) steady = 0;
    end
    bitClock(ackIt ? 1'b0 : 1'b1, lo, pre);
  endtask

  task automatic waitIdle(input string tag);
    int n = 0;
    while (busy && n < 5 * WRC) begin tick(1); n++; end
    check(tag, busy, 1'b0);
  endtask

  task automatic writeBytes(input logic pg, input logic [7:0] wa, input int n,
                            input logic [7:0] base, input string tag);
    logic a;
    startCond;
    sendByte(devB(pg, 1'b0), a); check({tag, " dev ack R3"}, a, 1'b1);
    sendByte(wa, a);             check({tag, " word ack R3"}, a, 1'b1);
    for (int i = 0; i < n; i++) begin
      sendByte(base + 8'(i), a);
      check({tag, " data ack R3"}, a, 1'b1);
    end
    stopCond;
  endtask

  task automatic randomRead(input logic pg, input logic [7:0] wa, input int n,
                            output logic [7:0] d [4]);
    logic a, st;
    startCond;
    sendByte(devB(pg, 1'b0), a);
    sendByte(wa, a);
    startCond;
    sendByte(devB(1'b0, 1'b1), a);
    for (int i = 0; i < n; i++) readByte(i != n - 1, d[i], st);
    stopCond;
  endtask

  task automatic t_reset;
    logic [7:0] d [4];
    check("R1 sdaOe after reset", sdaOe, 1'b0);
    check("R1 busy after reset", busy, 1'b0);
    randomRead(1'b1, 8'h80, 1, d);
    check("R1 erased byte", d[0], 8'hFF);
  endtask

  task automatic t_address;
    logic a, st; logic [7:0] d;
    startCond; sendByte(8'hB4, a); check("R2 wrong device code", a, 1'b0);
    stopCond;
    startCond; sendByte({4'b1010, 2'b11, 1'b0, 1'b1}, a); check("R2 wrong strap", a, 1'b0);
    stopCond;
    startCond; sendByte(devB(1'b1, 1'b1), a); check("R2 page bit ignored", a, 1'b1);
    readByte(1'b0, d, st);
    stopCond;
  endtask

  task automatic t_byteWrite;
    logic a; logic [7:0] d [4];
    writeBytes(1'b0, 8'h10, 1, 8'hA5, "bytewr");
    check("R6 busy after commit", busy, 1'b1);
    startCond; sendByte(devB(1'b0, 1'b1), a);
    check("R4 poll NACK while busy", a, 1'b0);
    stopCond;
    waitIdle("R4 busy ends");
    randomRead(1'b0, 8'h10, 1, d);
    check("R7 random read of written byte", d[0], 8'hA5);
  endtask

  task automatic t_pageWrite;
    logic [7:0] d [4];
    writeBytes(1'b0, 8'h1C, 6, 8'h40, "pagewr");
    waitIdle("R4 page busy ends");
    randomRead(1'b0, 8'h1C, 4, d);
    check("R8 seq byte 0", d[0], 8'h40);
    check("R8 seq byte 3", d[3], 8'h43);
    randomRead(1'b0, 8'h10, 2, d);
    check("R10 page rollover 0x10", d[0], 8'h44);
    check("R10 page rollover 0x11", d[1], 8'h45);
  endtask

  task automatic t_wrap;
    logic [7:0] d [4];
    writeBytes(1'b1, 8'hFF, 1, 8'h77, "top");
    waitIdle("R4 top busy ends");
    writeBytes(1'b0, 8'h00, 1, 8'h3C, "bottom");
    waitIdle("R4 bottom busy ends");
    randomRead(1'b1, 8'hFF, 2, d);
    check("R3 upper half via page bit", d[0], 8'h77);
    check("R8 wrap to address 0", d[1], 8'h3C);
  endtask

  task automatic t_protect;
    logic a; logic [7:0] d [4];
    wpIn = 1;
    startCond;
    sendByte(devB(1'b0, 1'b0), a); check("R5 dev ack under WP", a, 1'b1);
    sendByte(8'h20, a);            check("R5 word ack under WP", a, 1'b1);
    sendByte(8'h11, a);            check("R5 data NACK under WP", a, 1'b0);
    stopCond;
    check("R5 no write cycle", busy, 1'b0);
    wpIn = 0;
    randomRead(1'b0, 8'h20, 1, d);
    check("R5 memory unchanged", d[0], 8'hFF);
  endtask

  task automatic t_cancel;
    logic a, lo, pre; logic [7:0] d [4];
    startCond;
    sendByte(devB(1'b0, 1'b0), a);
    sendByte(8'h30, a);
    sendByte(8'h99, a);
    for (int i = 0; i < 3; i++) bitClock(1'b1, lo, pre);
    stopCond;
    check("R6 partial byte no commit", busy, 1'b0);
    randomRead(1'b0, 8'h30, 1, d);
    check("R6 partial byte memory", d[0], 8'hFF);
    startCond;
    sendByte(devB(1'b0, 1'b0), a);
    sendByte(8'h1E, a);
    stopCond;
    check("R6 dummy write no commit", busy, 1'b0);
    startCond; sendByte(devB(1'b0, 1'b1), a);
    readByte(1'b0, d[0], a); stopCond;
    check("R8 current read after dummy", d[0], 8'h42);
  endtask

  task automatic t_startCancel;
    logic a, st; logic [7:0] d [4]; logic [7:0] x;
    startCond;
    sendByte(devB(1'b0, 1'b0), a);
    sendByte(8'h31, a);
    sendByte(8'h55, a);
    startCond;
    sendByte(devB(1'b0, 1'b1), a);
    readByte(1'b0, x, st);
    stopCond;
    check("R9 start cancels write", busy, 1'b0);
    randomRead(1'b0, 8'h31, 1, d);
    check("R9 cancelled byte", d[0], 8'hFF);
  endtask

  task automatic t_currentAndNack;
    logic a, st, lo, pre, drove; logic [7:0] d [4]; logic [7:0] x;
    randomRead(1'b0, 8'h1C, 1, d);
    startCond; sendByte(devB(1'b0, 1'b1), a);
    readByte(1'b0, x, st);
    check("R8 current address read", x, 8'h41);
    check("R12 enable steady while SCL high", st, 1'b1);
    drove = 0;
    for (int i = 0; i < 9; i++) begin
      bitClock(1'b1, lo, pre);
      if (lo || pre) drove = 1;
    end
    check("R11 silent after master NACK", drove, 1'b0);
    stopCond;
    check("R11 released after stop", sdaOe, 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    tick(4); rst_n = 1; tick(2);
    t_reset;
    t_address;
    t_byteWrite;
    t_pageWrite;
    t_wrap;
    t_protect;
    t_cancel;
    t_startCancel;
    t_currentAndNack;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule